// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block decides when a descriptor-driven DMA engine should write its status block to host memory and when it should interrupt the host. It counts transmit and receive descriptor events. It also runs one tick timer per direction, clocked by the core clock. When an enabled count limit or tick limit is reached, or when software or a descriptor forces an update, the block asks an external status writer for an update with a valid/ready handshake. It then raises a one-cycle interrupt once the writer has taken the request.

Software drives the block through a 32-bit mode word. The word carries these controls:
- a self-clearing reset of the state machine
- an enable that lets an update in flight finish before the block halts
- a self-clearing force command, with an option to suppress its interrupt
- an option that lets descriptor force flags update without an interrupt
- a per-direction policy that keeps the tick timer idle until the first event in that direction
- a partial status size code
- three bits that replace the low bits of the message-interrupt data word

A further enable turns error flags into a one-cycle attention pulse.

Top module: `intr_coalesce_ctrl`

## Requirements
- R1: After `rst`, `cfg_rd_data` reads 0, and `upd_valid`, `irq` and `attn_out` are low.
- R2: The read value holds the written bits 1, 2 and 4 to 12. Bits 0, 3 and 13 to 31 always read 0.
- R3: Each direction counts its descriptor events while enabled. Once the count reaches a nonzero threshold, the block requests an update. A threshold of 0 disables that limit.
- R4: Each tick timer advances once per clock while enabled, and a nonzero tick threshold that is reached requests an update. When bit 10 (transmit) or bit 9 (receive) is set, that timer stays at zero after each clear until an event of its own direction arrives.
- R5: `upd_valid` stays high, with `upd_size` stable, until `upd_ready`. `upd_size` follows mode bits 8:7 (00 full, 01 64 bytes, 10 32 bytes), and code 11 is sent as 00.
- R6: An update that should interrupt drives `irq` high for exactly the one cycle that follows the valid/ready cycle. `irq_data` is `MSI_BASE` with bits 2:0 replaced by mode bits 6:4.
- R7: Writing bit 3 as 1 while enabled starts an update. The update interrupts unless bit 12 is 1 in that same write.
- R8: With bit 11 set, an event that has `evt_force` high forces an update without an interrupt. With bit 11 clear, `evt_force` does not force an update.
- R9: Forces that arrive while an update is in flight merge into one follow-up update. That update interrupts if any merged force asked for an interrupt.
- R10: Writing bit 0 as 1 clears the counters, the tick timers, the pending force and any request in flight. The other fields of that write are still stored.
- R11: Writing bit 1 as 0 lets a request in flight complete, and bit 1 reads 1 until it does. While disabled, the block starts no update and ignores events.
- R12: With bit 2 set, `attn_out` is high in the cycle after `err_in`. With bit 2 clear, `attn_out` stays low.
- R13: Every update start clears the event counts and tick timers, so the next update needs a full new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Mode word write strobe |
| cfg_wr_data | input | 32 | Mode word write value |
| cfg_rd_data | output | 32 | Mode word read value |
| tx_evt | input | 1 | Transmit descriptor event |
| rx_evt | input | 1 | Receive descriptor event |
| evt_force | input | 1 | Force flag carried with an event |
| tx_cnt_thr | input | CNT_W | Transmit event limit, 0 disables |
| rx_cnt_thr | input | CNT_W | Receive event limit, 0 disables |
| tx_tick_thr | input | TICK_W | Transmit tick limit, 0 disables |
| rx_tick_thr | input | TICK_W | Receive tick limit, 0 disables |
| err_in | input | 1 | Error flag |
| attn_out | output | 1 | Attention pulse |
| upd_valid | output | 1 | Status update request |
| upd_ready | input | 1 | Writer takes the request |
| upd_size | output | 2 | Status size code for the update |
| irq | output | 1 | One-cycle interrupt |
| irq_data | output | 16 | Message-interrupt data word |

## Verification
The bench keeps the default widths, with 8-bit counts and 16-bit tick timers. At those widths, event limits of 1 to 3 and tick limits of 20 complete in a few dozen cycles, while saturation stays far away. `MSI_BASE` is set to 16'hBEEF. That value has its low three bits all set, so the replacement by mode bits 6:4 shows up in every interrupt word. Holding `upd_ready` low keeps a request open, which makes merged forces, aborts by soft reset and the graceful halt visible.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int unsigned RST_BIT    = 0;
    localparam int unsigned EN_BIT     = 1;
    localparam int unsigned ATTN_BIT   = 2;
    localparam int unsigned NOW_BIT    = 3;
    localparam int unsigned MSI_LSB    = 4;
    localparam int unsigned SIZE_LSB   = 7;
    localparam int unsigned RXIDLE_BIT = 9;
    localparam int unsigned TXIDLE_BIT = 10;
    localparam int unsigned DESCQ_BIT  = 11;
    localparam int unsigned NOWQ_BIT   = 12;
    localparam int unsigned LIVE_W     = 13;
    localparam int unsigned NUM_DIR    = 2;

    typedef struct packed {
        logic       now_quiet;
        logic       desc_quiet;
        logic       tx_idle_ticks;
        logic       rx_idle_ticks;
        logic [1:0] size;
        logic [2:0] msi_lo;
        logic       attn_en;
        logic       enable;
    } mode_t;

    typedef struct packed {
        logic req;
        logic quiet;
    } force_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } upd_state_e;

    typedef enum logic [1:0] {
        SB_FULL  = 2'b00,
        SB_64B   = 2'b01,
        SB_32B   = 2'b10,
        SB_UNDEF = 2'b11
    } sb_size_e;

    function automatic logic [1:0] wire_size(input logic [1:0] code);
        return (code == SB_UNDEF) ? SB_FULL : code;
    endfunction

    function automatic logic [31:0] encode_mode(input mode_t m, input logic busy);
        logic [31:0] r;
        r = '0;
        r[EN_BIT]             = m.enable | busy;
        r[ATTN_BIT]           = m.attn_en;
        r[MSI_LSB +: 3]       = m.msi_lo;
        r[SIZE_LSB +: 2]      = m.size;
        r[RXIDLE_BIT]         = m.rx_idle_ticks;
        r[TXIDLE_BIT]         = m.tx_idle_ticks;
        r[DESCQ_BIT]          = m.desc_quiet;
        r[NOWQ_BIT]           = m.now_quiet;
        return r;
    endfunction

endpackage

// File: rtl/icc_mode_reg.sv
module icc_mode_reg
    import icc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        busy,
    output mode_t       mode,
    output logic [31:0] rd_data,
    output logic        soft_rst,
    output force_t      force_now
);

    logic rsvd_seen;

    assign rsvd_seen = |wr_data[31:LIVE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr_en) begin
            mode.enable        <= wr_data[EN_BIT];
            mode.attn_en       <= wr_data[ATTN_BIT];
            mode.msi_lo        <= wr_data[MSI_LSB +: 3];
            mode.size          <= wr_data[SIZE_LSB +: 2];
            mode.rx_idle_ticks <= wr_data[RXIDLE_BIT];
            mode.tx_idle_ticks <= wr_data[TXIDLE_BIT];
            mode.desc_quiet    <= wr_data[DESCQ_BIT];
            mode.now_quiet     <= wr_data[NOWQ_BIT];
        end
    end

    assign soft_rst        = wr_en & wr_data[RST_BIT];
    assign force_now.req   = wr_en & wr_data[NOW_BIT] & ~wr_data[RST_BIT];
    assign force_now.quiet = wr_data[NOWQ_BIT];
    assign rd_data         = encode_mode(mode, busy);

    // R2: reserved write bits never become visible
    assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rsvd_seen) |=> (rd_data[31:LIVE_W] == '0));

endmodule

// File: rtl/icc_dir_counter.sv
module icc_dir_counter #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic              evt,
    input  logic              idle_ticks,
    input  logic [CNT_W-1:0]  cnt_thr,
    input  logic [TICK_W-1:0] tick_thr,
    output logic              hit
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

    logic [CNT_W-1:0]  cnt;
    logic [TICK_W-1:0] tick;
    logic              seen;
    logic              tick_live;
    logic              cnt_hit;
    logic              tick_hit;

    assign tick_live = ~idle_ticks | seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= '0;
            seen <= 1'b0;
        end else if (clr) begin
            cnt  <= (run && evt) ? CNT_W'(1) : '0;
            seen <= run & evt;
            tick <= '0;
        end else if (run) begin
            if (evt && cnt != CNT_MAX) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (evt) begin
                seen <= 1'b1;
            end
            if (tick_live && tick != TICK_MAX) begin
                tick <= tick + TICK_W'(1);
            end
        end
    end

    assign cnt_hit  = (cnt_thr != '0) && (cnt >= cnt_thr);
    assign tick_hit = (tick_thr != '0) && (tick >= tick_thr);
    assign hit      = run & (cnt_hit | tick_hit);

    // R13: a clear leaves at most the event of that same cycle
    assert_clear_count_R13: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt <= CNT_W'(1)));

    // R11: nothing advances while disabled
    assert_frozen_R11: assert property (@(posedge clk) disable iff (rst || clr)
        !run |=> ($stable(cnt) && $stable(tick)));

    // R4: an idle timer stays at zero until an event arrives
    assert_tick_idle_R4: assert property (@(posedge clk) disable iff (rst || clr)
        (idle_ticks && !seen && !evt) |=> (tick == '0 || !idle_ticks));

endmodule

// File: rtl/icc_update_fsm.sv
module icc_update_fsm
    import icc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   trig,
    input  force_t force_in,
    input  logic   upd_ready,
    output logic   upd_valid,
    output logic   start,
    output logic   busy,
    output logic   irq
);

    upd_state_e state;
    logic       pend;
    logic       pend_quiet;
    logic       want_irq;
    logic       pend_n;
    logic       quiet_n;

    always_comb begin
        pend_n  = pend;
        quiet_n = pend_quiet;
        if (!en) begin
            pend_n  = 1'b0;
            quiet_n = 1'b1;
        end else if (force_in.req) begin
            quiet_n = pend ? (pend_quiet & force_in.quiet) : force_in.quiet;
            pend_n  = 1'b1;
        end
    end

    assign start     = (state == ST_IDLE) && en && (trig || pend_n);
    assign upd_valid = (state == ST_REQ);
    assign busy      = (state == ST_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pend       <= 1'b0;
            pend_quiet <= 1'b1;
            want_irq   <= 1'b0;
            irq        <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_REQ;
                        want_irq   <= trig | (pend_n & ~quiet_n);
                        pend       <= 1'b0;
                        pend_quiet <= 1'b1;
                    end else begin
                        pend       <= pend_n;
                        pend_quiet <= quiet_n;
                    end
                end
                ST_REQ: begin
                    pend       <= pend_n;
                    pend_quiet <= quiet_n;
                    if (upd_ready) begin
                        state <= ST_IDLE;
                        irq   <= want_irq;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_valid_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_ready) |=> upd_valid);

    assert_irq_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(upd_valid && upd_ready));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_halt_stays_R11: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !busy);

endmodule

// File: rtl/intr_coalesce_ctrl.sv
module intr_coalesce_ctrl
    import icc_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned TICK_W   = 16,
    parameter logic [15:0] MSI_BASE = 16'h4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              evt_force,
    input  logic [CNT_W-1:0]  tx_cnt_thr,
    input  logic [CNT_W-1:0]  rx_cnt_thr,
    input  logic [TICK_W-1:0] tx_tick_thr,
    input  logic [TICK_W-1:0] rx_tick_thr,
    input  logic              err_in,
    output logic              attn_out,
    output logic              upd_valid,
    input  logic              upd_ready,
    output logic [1:0]        upd_size,
    output logic              irq,
    output logic [15:0]       irq_data
);

    mode_t  mode;
    force_t force_now;
    force_t force_all;
    logic   soft_rst;
    logic   srst;
    logic   busy;
    logic   start;
    logic   desc_force;
    logic   attn_q;
    logic [1:0] size_q;
    logic [NUM_DIR-1:0] hit;
    logic [NUM_DIR-1:0] evt_v;
    logic [NUM_DIR-1:0] idle_v;
    logic [NUM_DIR-1:0][CNT_W-1:0]  cthr_v;
    logic [NUM_DIR-1:0][TICK_W-1:0] tthr_v;

    icc_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .busy     (busy),
        .mode     (mode),
        .rd_data  (cfg_rd_data),
        .soft_rst (soft_rst),
        .force_now(force_now)
    );

    assign srst       = rst | soft_rst;
    assign desc_force = evt_force & (tx_evt | rx_evt) & mode.desc_quiet;
    assign force_all.req   = force_now.req | desc_force;
    assign force_all.quiet = force_now.req ? force_now.quiet : 1'b1;

    assign evt_v  = {rx_evt, tx_evt};
    assign idle_v = {mode.rx_idle_ticks, mode.tx_idle_ticks};
    assign cthr_v = {rx_cnt_thr, tx_cnt_thr};
    assign tthr_v = {rx_tick_thr, tx_tick_thr};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        icc_dir_counter #(
            .CNT_W (CNT_W),
            .TICK_W(TICK_W)
        ) u_cnt (
            .clk       (clk),
            .rst       (srst),
            .clr       (start),
            .run       (mode.enable),
            .evt       (evt_v[d]),
            .idle_ticks(idle_v[d]),
            .cnt_thr   (cthr_v[d]),
            .tick_thr  (tthr_v[d]),
            .hit       (hit[d])
        );
    end

    icc_update_fsm u_fsm (
        .clk      (clk),
        .rst      (srst),
        .en       (mode.enable),
        .trig     (|hit),
        .force_in (force_all),
        .upd_ready(upd_ready),
        .upd_valid(upd_valid),
        .start    (start),
        .busy     (busy),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (srst) begin
            size_q <= SB_FULL;
        end else if (start) begin
            size_q <= wire_size(mode.size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attn_q <= 1'b0;
        end else begin
            attn_q <= err_in & mode.attn_en;
        end
    end

    assign upd_size = size_q;
    assign attn_out = attn_q;
    assign irq_data = {MSI_BASE[15:3], mode.msi_lo};

    assert_size_code_R5: assert property (@(posedge clk) disable iff (srst)
        upd_valid |-> (upd_size != SB_UNDEF));

    assert_size_stable_R5: assert property (@(posedge clk) disable iff (srst)
        (upd_valid && !upd_ready) |=> $stable(upd_size));

    assert_attn_cause_R12: assert property (@(posedge clk) disable iff (rst)
        attn_out |-> $past(err_in));

endmodule

// File: tb/intr_coalesce_ctrl_test.sv
`timescale 1ns/1ps
module intr_coalesce_ctrl_test;

    localparam int unsigned CW = 8;
    localparam int unsigned TW = 16;
    localparam logic [15:0] BASE = 16'hBEEF;
    localparam logic [15:0] D0   = {BASE[15:3], 3'b000};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr_en = 1'b0;
    logic [31:0]   cfg_wr_data = '0;
    logic [31:0]   cfg_rd_data;
    logic          tx_evt = 1'b0, rx_evt = 1'b0, evt_force = 1'b0;
    logic [CW-1:0] tx_cnt_thr = '0, rx_cnt_thr = '0;
    logic [TW-1:0] tx_tick_thr = '0, rx_tick_thr = '0;
    logic          err_in = 1'b0;
    logic          attn_out, upd_valid, upd_ready, irq;
    logic [1:0]    upd_size;
    logic [15:0]   irq_data;
    logic          hold = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic [1:0] size; logic want; logic [15:0] data; } exp_t;
    exp_t q[$];

    logic        irq_due = 1'b0;
    logic        irq_exp = 1'b0;
    logic [15:0] data_exp = '0;

    assign upd_ready = ~hold;

    always #2 clk = ~clk;

    intr_coalesce_ctrl #(.CNT_W(CW), .TICK_W(TW), .MSI_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .evt_force(evt_force), .tx_cnt_thr(tx_cnt_thr), .rx_cnt_thr(rx_cnt_thr),
        .tx_tick_thr(tx_tick_thr), .rx_tick_thr(rx_tick_thr), .err_in(err_in),
        .attn_out(attn_out), .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_size(upd_size), .irq(irq), .irq_data(irq_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] s, input logic w, input logic [15:0] d);
        exp_t e;
        e.size = s; e.want = w; e.data = d;
        q.push_back(e);
    endtask

    // monitor: compares each handshake and the interrupt that follows it
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (irq_due) begin
                irq_due = 1'b0;
                chk("R6", "irq after ack", {31'd0, irq}, {31'd0, irq_exp});
                if (irq_exp) chk("R6", "irq data", {16'd0, irq_data}, {16'd0, data_exp});
            end else if (irq) begin
                chk("R6", "stray irq", 32'd1, 32'd0);
            end
            if (upd_valid && upd_ready) begin
                if (q.size() == 0) begin
                    chk("R3", "unexpected update", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R5", "update size", {30'd0, upd_size}, {30'd0, e.size});
                    irq_due  = 1'b1;
                    irq_exp  = e.want;
                    data_exp = e.data;
                end
            end
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_data = '0;
    endtask

    task automatic ev(input logic t, input logic r, input logic f);
        @(negedge clk);
        tx_evt = t; rx_evt = r; evt_force = f;
        @(negedge clk);
        tx_evt = 1'b0; rx_evt = 1'b0; evt_force = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 60 && q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(req, "expected updates seen", q.size(), 0);
    endtask

    task automatic idle(input int n, input string req);
        repeat (n) @(negedge clk);
        chk(req, "no request", {31'd0, upd_valid}, 32'd0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "read after reset", cfg_rd_data, 32'd0);
        chk("R1", "valid after reset", {31'd0, upd_valid}, 32'd0);
        chk("R1", "irq/attn after reset", {30'd0, irq, attn_out}, 32'd0);

        // R2 readback
        wr(32'hFFFF_FFF6);
        chk("R2", "readback all fields", cfg_rd_data, 32'h0000_1FF6);
        wr(32'h0);
        chk("R2", "readback cleared", cfg_rd_data, 32'd0);

        // R3 / R13 event counting
        wr(32'h3);
        tx_cnt_thr = 8'd3;
        ev(1, 0, 0); ev(1, 0, 0);
        idle(10, "R3");
        push(2'b00, 1'b1, D0);
        ev(1, 0, 0);
        drain("R3");
        ev(1, 0, 0); ev(1, 0, 0);
        idle(10, "R13");
        push(2'b00, 1'b1, D0);
        ev(1, 0, 0);
        drain("R13");
        tx_cnt_thr = '0;

        // R5 size codes via receive limit
        wr(32'h83);
        rx_cnt_thr = 8'd2;
        push(2'b01, 1'b1, D0);
        ev(0, 1, 0); ev(0, 1, 0);
        drain("R5");
        wr(32'h183);
        push(2'b00, 1'b1, D0);
        ev(0, 1, 0); ev(0, 1, 0);
        drain("R5");
        wr(32'h103);
        push(2'b10, 1'b1, D0);
        ev(0, 1, 0); ev(0, 1, 0);
        drain("R5");
        rx_cnt_thr = '0;

        // R4 free-running tick limit
        wr(32'h3);
        tx_tick_thr = 16'd20;
        idle(14, "R4");
        push(2'b00, 1'b1, D0);
        drain("R4");
        tx_tick_thr = '0;

        // R4 tick timer idle until a transmit event
        wr(32'h403);
        tx_tick_thr = 16'd20;
        idle(60, "R4");
        push(2'b00, 1'b1, D0);
        ev(1, 0, 0);
        drain("R4");
        idle(60, "R4");
        tx_tick_thr = '0;

        // R7 force now, with and without interrupt; R6 data bits
        wr(32'h3);
        push(2'b00, 1'b1, D0);
        wr(32'hA);
        drain("R7");
        chk("R7", "force bit self-clears", cfg_rd_data, 32'h2);
        push(2'b00, 1'b0, D0);
        wr(32'h100A);
        drain("R7");
        push(2'b00, 1'b1, {BASE[15:3], 3'b101});
        wr(32'h5A);
        drain("R6");

        // R8 descriptor force
        wr(32'h803);
        push(2'b00, 1'b0, D0);
        ev(1, 0, 1);
        drain("R8");
        wr(32'h3);
        ev(1, 0, 1);
        idle(10, "R8");

        // R9 merged forces
        hold = 1'b1;
        wr(32'hA);
        wr(32'h100A);
        wr(32'h100A);
        chk("R5", "valid held without ready", {31'd0, upd_valid}, 32'd1);
        push(2'b00, 1'b1, D0);
        push(2'b00, 1'b0, D0);
        hold = 1'b0;
        drain("R9");
        hold = 1'b1;
        wr(32'hA);
        wr(32'h100A);
        wr(32'hA);
        push(2'b00, 1'b1, D0);
        push(2'b00, 1'b1, D0);
        hold = 1'b0;
        drain("R9");

        // R11 graceful halt
        hold = 1'b1;
        wr(32'hA);
        repeat (3) @(negedge clk);
        wr(32'h0);
        chk("R11", "enable reads 1 while busy", cfg_rd_data, 32'h2);
        push(2'b00, 1'b1, D0);
        hold = 1'b0;
        drain("R11");
        chk("R11", "enable reads 0 after halt", cfg_rd_data, 32'h0);
        wr(32'h1);
        tx_cnt_thr = 8'd1;
        ev(1, 0, 0); ev(1, 0, 0); ev(1, 0, 0);
        idle(10, "R11");
        wr(32'h2);
        idle(10, "R11");
        tx_cnt_thr = '0;

        // R10 soft reset aborts a request and clears counts
        wr(32'h3);
        hold = 1'b1;
        wr(32'hA);
        chk("R10", "request open", {31'd0, upd_valid}, 32'd1);
        wr(32'h3);
        chk("R10", "request dropped", {31'd0, upd_valid}, 32'd0);
        chk("R10", "fields kept", cfg_rd_data, 32'h2);
        hold = 1'b0;
        idle(10, "R10");
        tx_cnt_thr = 8'd3;
        ev(1, 0, 0); ev(1, 0, 0);
        wr(32'h3);
        ev(1, 0, 0); ev(1, 0, 0);
        idle(10, "R10");
        push(2'b00, 1'b1, D0);
        ev(1, 0, 0);
        drain("R10");
        tx_cnt_thr = '0;

        // R12 attention
        wr(32'h6);
        @(negedge clk); err_in = 1'b1;
        @(negedge clk); err_in = 1'b0;
        chk("R12", "attention pulse", {31'd0, attn_out}, 32'd1);
        @(negedge clk);
        chk("R12", "attention one cycle", {31'd0, attn_out}, 32'd0);
        wr(32'h2);
        @(negedge clk); err_in = 1'b1;
        @(negedge clk); err_in = 1'b0;
        chk("R12", "attention gated", {31'd0, attn_out}, 32'd0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule